// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column addresses of a single SDRAM read or write burst. A one-cycle start pulse captures a starting column, a three-bit length code and an ordering bit. From the next cycle on, the block presents one column per beat together with a valid flag and a last-beat flag. A downstream consumer accepts each beat with a ready input, and while ready is low the current address is held.

Ordering is either linear, wrapping inside the aligned block of the burst length, or exclusive-or based (interleaved). A full-page mode runs linearly through the whole row until it is stopped or replaced. A stop input ends a burst at once. A new start replaces the running burst on any cycle, so no alignment to pairs of cycles is required. A start with a length code that has no meaning raises a one-cycle error pulse and issues no addresses.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, and until the first start, col_valid_o, col_last_o and err_o are all 0.
- R2: A start with a legal code makes col_valid_o 1 in the following cycle, with col_addr_o equal to the captured start column.
- R3: With order_i = 0 (linear), beat i has address bits above the burst-length boundary equal to the start column, and the low bits equal to (start low bits + i) modulo the burst length.
- R4: With order_i = 1 (interleaved), beat i has the low bits equal to the start low bits XOR i, and the upper bits equal to the start column.
- R5: len_code_i 000, 001, 010 and 011 select bursts of 1, 2, 4 and 8 beats; col_last_o is 1 only on the final beat, and col_valid_o is 0 in the cycle after the final beat is accepted.
- R6: len_code_i 111 with order_i = 0 selects full page: the address counts up by one per accepted beat, wraps from 255 to 0, never ends by itself and never raises col_last_o.
- R7: Codes 100, 101, 110 with either order, and 111 with order_i = 1, are reserved: err_o is 1 for exactly the cycle after the start, col_valid_o is 0 then, and a burst in progress is dropped.
- R8: stop_i without start_i makes col_valid_o 0 in the next cycle; when start_i and stop_i are both 1, the start wins.
- R9: A start during a running burst, on any beat, replaces it: the next cycle shows the first address of the new burst.
- R10: While col_valid_o is 1 and col_ready_i is 0 (no start or stop), col_addr_o and col_valid_o stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 linear, 1 interleaved |
| stop_i | input | 1 | End the running burst |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_valid_o | output | 1 | Current column is valid |
| col_addr_o | output | 8 | Current column address |
| col_last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Reserved code seen at last start |

## Verification
The bench targets the wrap points: a linear burst whose start sits mid-block must fold back inside its aligned block rather than carry into the upper bits, an interleaved burst must flip low bits instead of counting, and a full-page burst started near 255 must roll to 0 without raising the last flag. It replaces a running burst on an odd beat and lets start collide with stop; a design with a pairwise alignment rule or the wrong priority would keep emitting old columns. It stalls with ready low, where a counter that ignored the handshake would skip columns, and it issues reserved codes both idle and mid-burst, where a lax decoder would emit addresses or leave the old burst alive.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // largest fixed length code is log2 of the longest fixed burst
  localparam int unsigned MAX_FIXED_LOG = 3;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             order_i,
  output logic             legal_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);
  localparam logic [LEN_W-1:0] FULL_CODE = {LEN_W{1'b1}};

  logic fixed_w;

  assign full_o  = (len_code_i == FULL_CODE) && (order_e'(order_i) == ORD_LINEAR);
  assign fixed_w = (32'(len_code_i) <= MAX_FIXED_LOG);
  assign legal_o = full_o | fixed_w;

  // mask = burst length - 1, all ones for full page
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o | (fixed_w & (32'(b) < 32'(len_code_i)));
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (adv_i)  beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;
  assign last_o = !full_i && (beat_q == mask_i);
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic             order_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] low_w;

  always_comb begin
    if (order_e'(order_i) == ORD_XOR) low_w = base_i ^ beat_i;
    else                              low_w = base_i + beat_i;
    addr_o = (base_i & ~mask_i) | (low_w & mask_i);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             order_i,
  input  logic             stop_i,
  input  logic             col_ready_i,
  output logic             col_valid_o,
  output logic [COL_W-1:0] col_addr_o,
  output logic             col_last_o,
  output logic             err_o
);
  logic             legal_w, full_w;
  logic [COL_W-1:0] mask_w;
  logic [COL_W-1:0] base_q, mask_q, beat_w;
  logic             full_q, order_q, valid_q, err_q;
  logic             last_w, accept_w, load_w;

  burst_cfg_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
    .len_code_i (len_code_i),
    .order_i    (order_i),
    .legal_o    (legal_w),
    .full_o     (full_w),
    .mask_o     (mask_w)
  );

  assign accept_w = valid_q & col_ready_i;
  assign load_w   = start_i & legal_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      err_q   <= !legal_w;
      valid_q <= legal_w;
      if (legal_w) begin
        base_q  <= start_col_i;
        mask_q  <= mask_w;
        full_q  <= full_w;
        order_q <= order_i;
      end
    end else begin
      err_q <= 1'b0;
      if (stop_i)                  valid_q <= 1'b0;
      else if (accept_w && last_w) valid_q <= 1'b0;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .adv_i  (accept_w & !start_i & !stop_i),
    .mask_i (mask_q),
    .full_i (full_q),
    .beat_o (beat_w),
    .last_o (last_w)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_i  (base_q),
    .mask_i  (mask_q),
    .beat_i  (beat_w),
    .order_i (order_q),
    .addr_o  (col_addr_o)
  );

  assign col_valid_o = valid_q;
  assign col_last_o  = valid_q & last_w;
  assign err_o       = err_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [LEN_W-1:0] len_code_i,
  input logic             stop_i,
  input logic             col_ready_i,
  input logic             col_valid_o,
  input logic [COL_W-1:0] col_addr_o,
  input logic             col_last_o,
  input logic             err_o
);
  // R2
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (32'(len_code_i) <= 3)) |=> (col_valid_o && col_addr_o == $past(start_col_i)));

  // R5
  end_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_last_o && col_ready_i && !start_i) |=> !col_valid_o);

  // R5
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last_o |-> col_valid_o);

  // R7
  err_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !col_valid_o);

  // R7
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> !err_o);

  // R8
  stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !col_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && !col_ready_i && !start_i && !stop_i) |=> (col_valid_o && $stable(col_addr_o)));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .stop_i      (stop_i),
  .col_ready_i (col_ready_i),
  .col_valid_o (col_valid_o),
  .col_addr_o  (col_addr_o),
  .col_last_o  (col_last_o),
  .err_o       (err_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       col_ready_i = 1'b1;
  logic       col_valid_o;
  logic [7:0] col_addr_o;
  logic       col_last_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  burst_col_gen u_burst_col_gen (.*);

  // {order, len code, start column}
  localparam int NVEC = 9;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 8'h37}, {1'b0, 3'd1, 8'h45}, {1'b0, 3'd2, 8'h3E},
    {1'b0, 3'd3, 8'hA5}, {1'b0, 3'd2, 8'h3D}, {1'b1, 3'd2, 8'h3D},
    {1'b1, 3'd3, 8'h5B}, {1'b1, 3'd1, 8'hFF}, {1'b1, 3'd0, 8'h00}
  };

  function automatic logic [7:0] exp_addr(logic [7:0] col, logic [2:0] code, logic ord, int i);
    logic [7:0] m, lo;
    m  = (code == 3'd7) ? 8'hFF : 8'((1 << code) - 1);
    lo = ord ? (col ^ 8'(i)) : (col + 8'(i));
    return (col & ~m) | (lo & m);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input string req, input logic [7:0] a, input logic l);
    check(col_valid_o === 1'b1, {req, " valid"}, 32'(col_valid_o), 1);
    check(col_addr_o === a, {req, " addr"}, 32'(col_addr_o), 32'(a));
    check(col_last_o === l, {req, " last"}, 32'(col_last_o), 32'(l));
  endtask

  task automatic launch(input logic [7:0] c, input logic [2:0] code, input logic ord);
    start_i = 1'b1; start_col_i = c; len_code_i = code; order_i = ord;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    @(negedge clk_i);
    check(col_valid_o === 1'b0, "R1 valid", 32'(col_valid_o), 0);
    check(col_last_o === 1'b0, "R1 last", 32'(col_last_o), 0);
    check(err_o === 1'b0, "R1 err", 32'(err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(col_valid_o === 1'b0, "R1 idle after reset", 32'(col_valid_o), 0);

    // R2 R3 R4 R5 vector table
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v][7:0], VEC[v][10:8], VEC[v][11]);
      for (int i = 0; i < (1 << VEC[v][10:8]); i++) begin
        beat(VEC[v][11] ? "R4 xor order" : "R3 linear order",
             exp_addr(VEC[v][7:0], VEC[v][10:8], VEC[v][11], i),
             i == (1 << VEC[v][10:8]) - 1);
        @(negedge clk_i);
      end
      check(col_valid_o === 1'b0, "R5 end of burst", 32'(col_valid_o), 0);
    end

    // R6 full page wraps 255 -> 0, stopped by R8
    launch(8'hFB, 3'd7, 1'b0);
    for (int i = 0; i < 10; i++) begin
      beat("R6 full page", 8'(8'hFB + i), 1'b0);
      if (i == 9) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check(col_valid_o === 1'b0, "R8 stop", 32'(col_valid_o), 0);

    // R7 reserved code while idle
    launch(8'h12, 3'd5, 1'b0);
    check(err_o === 1'b1, "R7 err idle", 32'(err_o), 1);
    check(col_valid_o === 1'b0, "R7 no valid", 32'(col_valid_o), 0);
    @(negedge clk_i);
    check(err_o === 1'b0, "R7 err one cycle", 32'(err_o), 0);

    // R7 full page with xor order aborts a running burst
    launch(8'h10, 3'd3, 1'b0);
    beat("R3 before abort", 8'h10, 1'b0);
    launch(8'h40, 3'd7, 1'b1);
    check(err_o === 1'b1, "R7 err mid burst", 32'(err_o), 1);
    check(col_valid_o === 1'b0, "R7 burst dropped", 32'(col_valid_o), 0);
    @(negedge clk_i);
    check(col_valid_o === 1'b0, "R7 stays idle", 32'(col_valid_o), 0);

    // R9 restart on an odd beat
    launch(8'h20, 3'd3, 1'b0);
    beat("R9 old beat0", 8'h20, 1'b0);
    @(negedge clk_i);
    beat("R9 old beat1", 8'h21, 1'b0);
    launch(8'h81, 3'd2, 1'b1);
    beat("R9 new beat0", 8'h81, 1'b0);
    @(negedge clk_i);
    beat("R9 new beat1", 8'h80, 1'b0);
    @(negedge clk_i);
    beat("R9 new beat2", 8'h83, 1'b0);
    @(negedge clk_i);
    beat("R9 new beat3", 8'h82, 1'b1);
    @(negedge clk_i);
    check(col_valid_o === 1'b0, "R9 new burst ends", 32'(col_valid_o), 0);

    // R10 stall holds the beat
    launch(8'h06, 3'd2, 1'b0);
    beat("R10 beat0", 8'h06, 1'b0);
    col_ready_i = 1'b0;
    @(negedge clk_i);
    beat("R10 stall1", 8'h06, 1'b0);
    @(negedge clk_i);
    beat("R10 stall2", 8'h06, 1'b0);
    col_ready_i = 1'b1;
    @(negedge clk_i);
    beat("R10 resume", 8'h07, 1'b0);
    @(negedge clk_i);
    beat("R10 wrap", 8'h04, 1'b0);

    // R8 start beats a simultaneous stop
    stop_i = 1'b1;
    launch(8'h30, 3'd1, 1'b0);
    stop_i = 1'b0;
    beat("R8 start wins", 8'h30, 1'b0);
    @(negedge clk_i);
    beat("R8 start wins beat1", 8'h31, 1'b1);

    finish_run();
  end
endmodule